// File: doc/BRIEF.md
# Ethernet Receive Frame Fetcher

This block takes one received frame out of the circular receive memory of an Ethernet controller. It does this by issuing byte-wide commands to a register access engine, which serializes them on the controller's serial link. A fetch begins with a single `start` pulse. The block first reads the count of pending frames and stops at once if the count is zero. Otherwise it points the controller's buffer read pointer at the frame it expects next and reads the six-byte receive header. The header carries the link to the following frame, the stored byte count and the receive status.

When the status marks the frame as received correctly, the block streams the payload bytes on a valid/ready byte port and flags the final byte. The delivered count is the stored count minus the four CRC bytes, limited by a caller-supplied maximum. When the receive status is bad, nothing is streamed. In both cases the block then hands the frame's memory back to the controller and bit-sets the counter decrement. It finishes with a one-cycle done pulse that carries the delivered length and a frame-ok flag. The link to the following frame is kept across fetches, so the next fetch starts where this frame ended.

Top module: `eth_rx_fetch`

## Requirements
- R1: After reset the block is idle: `cmd_valid`, `pl_valid` and `done` are low.
- R2: Command kinds are encoded on `cmd_kind` as 0 = register read, 1 = register write, 2 = bit-field set, 3 = buffer byte read. A command's kind, address and data stay stable while `cmd_valid` is high and `cmd_ready` is low. Only one command is outstanding: after a command is accepted, no new `cmd_valid` appears until `rsp_valid` has returned for it.
- R3: A fetch starts with a register read of address 0x39 (pending-frame count). If `rsp_data` for that read is zero, no further command is issued and `done` reports length 0 with `done_ok` low.
- R4: After a nonzero count, the block writes the stored frame pointer to the buffer read pointer: the low byte to address 0x00, then the high byte to address 0x01. After reset the stored pointer equals parameter `RX_START` (default 0x0000).
- R5: Six buffer byte reads then fetch the header in this order: next-frame pointer low, then high; byte count low, then high; status low, then high.
- R6: The delivered length is the byte count minus 4 (0 if the count is below 4), limited to `max_len - 1` (0 when `max_len` is 0).
- R7: If bit 7 of the status low byte is 0, `done_ok` is low, `done_len` is 0, and no payload reads or payload bytes occur.
- R8: Each payload byte takes one buffer read and is shown on `pl_data` with `pl_valid` until `pl_ready`. No command is issued while a byte waits. `pl_last` marks exactly the final byte. A good frame whose delivered length is 0 streams nothing.
- R9: After the header and payload, the block writes the header's next-frame pointer to address 0x0C (low) and 0x0D (high), then bit-field sets address 0x1E with data 0x40. That pointer becomes the stored pointer for the next fetch.
- R10: `done` is a single-cycle pulse, once per fetch, after the last command's response. It carries `done_len` and `done_ok`, and `done_ok` equals status bit 7.
- R11: A `start` pulse while a fetch is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one fetch |
| max_len | input | 16 | Caller limit; at most max_len-1 bytes are delivered |
| cmd_valid | output | 1 | Command request to the access engine |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_kind | output | 2 | Command kind (see R2) |
| cmd_addr | output | 8 | Register address, bank bits included |
| cmd_wdata | output | 8 | Write or bit-set data |
| rsp_valid | input | 1 | Engine finished the outstanding command |
| rsp_data | input | 8 | Read data returned with rsp_valid |
| pl_valid | output | 1 | Payload byte available |
| pl_ready | input | 1 | Payload consumer takes the byte |
| pl_data | output | 8 | Payload byte |
| pl_last | output | 1 | Final payload byte of the frame |
| done | output | 1 | Fetch finished (one cycle) |
| done_len | output | 16 | Number of bytes delivered |
| done_ok | output | 1 | Frame status reported good |

## Verification
The bench builds the block with `RX_START` set to 0x0120 instead of zero. A pointer register stuck at its reset value, or one that ignores the parameter, then shows up in the very first pointer write. It also means a missed pointer update is seen on every later fetch. Byte counts up to 64 and limits up to 70 are mixed with directed values 0, 1, 2, 4, 5, 14 and 15. These place the CRC underflow, the zero limit and the exact-cap boundary inside the runs. Random engine latency and payload back-pressure exercise the hold and stall rules.

// File: rtl/eth_rx_fetch_pkg.sv
package eth_rx_fetch_pkg;

  typedef enum logic [1:0] {
    K_RDREG  = 2'd0,
    K_WRREG  = 2'd1,
    K_BITSET = 2'd2,
    K_RDBUF  = 2'd3
  } cmd_kind_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CNT,
    S_SETL,
    S_SETH,
    S_HDR,
    S_EVAL,
    S_PL_RD,
    S_PL_OUT,
    S_FREEL,
    S_FREEH,
    S_DEC,
    S_DONE
  } fetch_st_e;

endpackage

// File: rtl/eth_rx_hdr.sv
module eth_rx_hdr #(
  parameter int DW     = 8,
  parameter int OK_BIT = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [2:0]    idx,
  input  logic [DW-1:0] din,
  output logic [2*DW-1:0] nxt_ptr,
  output logic [2*DW-1:0] byte_cnt,
  output logic          rx_ok
);
  localparam int KEEP = 4;
  localparam logic [2:0] STAT_IDX = 3'd4;

  logic [DW-1:0] hb [KEEP];

  for (genvar g = 0; g < KEEP; g++) begin : g_byte
    logic en;
    assign en = cap_en && (idx == 3'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  hb[g] <= '0;
      else if (en) hb[g] <= din;
    end
  end

  logic ok_en;
  assign ok_en = cap_en && (idx == STAT_IDX);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rx_ok <= 1'b0;
    else if (ok_en) rx_ok <= din[OK_BIT];
  end

  assign nxt_ptr  = {hb[1], hb[0]};
  assign byte_cnt = {hb[3], hb[2]};

  // R5: header bytes arrive only at the six defined positions
  a_r5_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |-> (idx <= 3'd5));

endmodule

// File: rtl/eth_rx_len.sv
module eth_rx_len #(
  parameter int LW        = 16,
  parameter int CRC_BYTES = 4
) (
  input  logic [LW-1:0] byte_cnt,
  input  logic [LW-1:0] max_len,
  output logic [LW-1:0] len
);
  localparam logic [LW-1:0] CRC = LW'(CRC_BYTES);

  logic [LW-1:0] raw, cap;

  always_comb begin
    raw = (byte_cnt < CRC) ? '0 : (byte_cnt - CRC);
    cap = (max_len == '0) ? '0 : (max_len - 1'b1);
    len = (raw > cap) ? cap : raw;
  end

endmodule

// File: rtl/eth_rx_seq.sv
module eth_rx_seq
  import eth_rx_fetch_pkg::*;
#(
  parameter int DW = 8,
  parameter int LW = 16,
  parameter int AW = 8,
  parameter int HDR_BYTES = 6,
  parameter logic [LW-1:0] RX_START = '0,
  parameter logic [AW-1:0] CNT_REG  = 8'h39,
  parameter logic [AW-1:0] RDPT_L   = 8'h00,
  parameter logic [AW-1:0] RDPT_H   = 8'h01,
  parameter logic [AW-1:0] FREE_L   = 8'h0C,
  parameter logic [AW-1:0] FREE_H   = 8'h0D,
  parameter logic [AW-1:0] CTRL_REG = 8'h1E,
  parameter logic [DW-1:0] DEC_MASK = 8'h40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [1:0]    cmd_kind,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_wdata,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic          hdr_cap,
  output logic [2:0]    hdr_idx,
  input  logic [LW-1:0] nxt_ptr,
  input  logic [LW-1:0] calc_len,
  input  logic          calc_ok,
  output logic          pl_valid,
  input  logic          pl_ready,
  output logic [DW-1:0] pl_data,
  output logic          pl_last,
  output logic          done,
  output logic [LW-1:0] done_len,
  output logic          done_ok
);
  localparam logic [2:0] HDR_LAST = 3'(HDR_BYTES - 1);

  fetch_st_e     st_q, st_d;
  logic          pend_q, pend_d;
  logic [2:0]    idx_q, idx_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic [LW-1:0] dlen_q, dlen_d;
  logic          ok_q, ok_d;
  logic [LW-1:0] ptr_q, ptr_d;
  logic [DW-1:0] pdat_q, pdat_d;
  logic          is_cmd, rsp_hit, last_byte;
  cmd_kind_e     kind;

  // command selection per state
  always_comb begin
    is_cmd    = 1'b1;
    kind      = K_RDBUF;
    cmd_addr  = '0;
    cmd_wdata = '0;
    unique case (st_q)
      S_CNT:   begin kind = K_RDREG;  cmd_addr = CNT_REG; end
      S_SETL:  begin kind = K_WRREG;  cmd_addr = RDPT_L;   cmd_wdata = ptr_q[DW-1:0]; end
      S_SETH:  begin kind = K_WRREG;  cmd_addr = RDPT_H;   cmd_wdata = ptr_q[LW-1:DW]; end
      S_HDR,
      S_PL_RD: kind = K_RDBUF;
      S_FREEL: begin kind = K_WRREG;  cmd_addr = FREE_L;   cmd_wdata = nxt_ptr[DW-1:0]; end
      S_FREEH: begin kind = K_WRREG;  cmd_addr = FREE_H;   cmd_wdata = nxt_ptr[LW-1:DW]; end
      S_DEC:   begin kind = K_BITSET; cmd_addr = CTRL_REG; cmd_wdata = DEC_MASK; end
      default: is_cmd = 1'b0;
    endcase
  end

  assign cmd_kind  = kind;
  assign cmd_valid = is_cmd && !pend_q;
  assign rsp_hit   = pend_q && rsp_valid;
  assign hdr_cap   = rsp_hit && (st_q == S_HDR);
  assign hdr_idx   = idx_q;
  assign last_byte = (cnt_q == (dlen_q - 1'b1));
  assign pl_valid  = (st_q == S_PL_OUT);
  assign pl_data   = pdat_q;
  assign pl_last   = pl_valid && last_byte;
  assign done      = (st_q == S_DONE);
  assign done_len  = dlen_q;
  assign done_ok   = ok_q;

  // next-state logic
  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    idx_d  = idx_q;
    cnt_d  = cnt_q;
    dlen_d = dlen_q;
    ok_d   = ok_q;
    ptr_d  = ptr_q;
    pdat_d = pdat_q;
    if (cmd_valid && cmd_ready) pend_d = 1'b1;
    if (rsp_hit) begin
      pend_d = 1'b0;
      unique case (st_q)
        S_CNT: begin
          if (rsp_data == '0) begin
            dlen_d = '0;
            ok_d   = 1'b0;
            st_d   = S_DONE;
          end else begin
            st_d = S_SETL;
          end
        end
        S_SETL: st_d = S_SETH;
        S_SETH: begin st_d = S_HDR; idx_d = '0; end
        S_HDR: begin
          idx_d = idx_q + 3'd1;
          if (idx_q == HDR_LAST) st_d = S_EVAL;
        end
        S_PL_RD: begin pdat_d = rsp_data; st_d = S_PL_OUT; end
        S_FREEL: st_d = S_FREEH;
        S_FREEH: begin ptr_d = nxt_ptr; st_d = S_DEC; end
        S_DEC:   st_d = S_DONE;
        default: ;
      endcase
    end
    unique case (st_q)
      S_IDLE: if (start) st_d = S_CNT;
      S_EVAL: begin
        dlen_d = calc_ok ? calc_len : '0;
        ok_d   = calc_ok;
        cnt_d  = '0;
        st_d   = (calc_ok && (calc_len != '0)) ? S_PL_RD : S_FREEL;
      end
      S_PL_OUT: if (pl_ready) begin
        cnt_d = cnt_q + 1'b1;
        st_d  = last_byte ? S_FREEL : S_PL_RD;
      end
      S_DONE: st_d = S_IDLE;
      default: ;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      pend_q <= 1'b0;
      idx_q  <= '0;
      cnt_q  <= '0;
      dlen_q <= '0;
      ok_q   <= 1'b0;
      ptr_q  <= RX_START;
      pdat_q <= '0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      idx_q  <= idx_d;
      cnt_q  <= cnt_d;
      dlen_q <= dlen_d;
      ok_q   <= ok_d;
      ptr_q  <= ptr_d;
      pdat_q <= pdat_d;
    end
  end

  // R2: command fields held while waiting for acceptance
  a_r2_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_kind)
                                   && $stable(cmd_addr) && $stable(cmd_wdata)));

  // R2: an accepted command is not followed by another in the next cycle
  a_r2_one_out: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_valid);

  // R8: payload byte held under back-pressure
  a_r8_pl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_valid && !pl_ready) |=> (pl_valid && $stable(pl_data) && $stable(pl_last)));

  // R8: engine traffic stalls while a byte waits
  a_r8_stall: assert property (@(posedge clk) disable iff (!rst_n)
    pl_valid |-> !cmd_valid);

  // R7: a bad frame never reports a length
  a_r7_bad_len: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_ok) |-> (done_len == '0));

  // R10: done lasts one cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/eth_rx_fetch.sv
module eth_rx_fetch #(
  parameter int DW        = 8,
  parameter int AW        = 8,
  parameter int CRC_BYTES = 4,
  parameter int OK_BIT    = 7,
  parameter logic [2*DW-1:0] RX_START = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2*DW-1:0] max_len,
  output logic            cmd_valid,
  input  logic            cmd_ready,
  output logic [1:0]      cmd_kind,
  output logic [AW-1:0]   cmd_addr,
  output logic [DW-1:0]   cmd_wdata,
  input  logic            rsp_valid,
  input  logic [DW-1:0]   rsp_data,
  output logic            pl_valid,
  input  logic            pl_ready,
  output logic [DW-1:0]   pl_data,
  output logic            pl_last,
  output logic            done,
  output logic [2*DW-1:0] done_len,
  output logic            done_ok
);
  localparam int LW = 2 * DW;

  logic          hdr_cap, rx_ok;
  logic [2:0]    hdr_idx;
  logic [LW-1:0] nxt_ptr, byte_cnt, calc_len;

  eth_rx_hdr #(.DW(DW), .OK_BIT(OK_BIT)) u_hdr (
    .clk(clk), .rst_n(rst_n), .cap_en(hdr_cap), .idx(hdr_idx), .din(rsp_data),
    .nxt_ptr(nxt_ptr), .byte_cnt(byte_cnt), .rx_ok(rx_ok)
  );

  eth_rx_len #(.LW(LW), .CRC_BYTES(CRC_BYTES)) u_len (
    .byte_cnt(byte_cnt), .max_len(max_len), .len(calc_len)
  );

  eth_rx_seq #(.DW(DW), .LW(LW), .AW(AW), .RX_START(RX_START)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .hdr_cap(hdr_cap), .hdr_idx(hdr_idx), .nxt_ptr(nxt_ptr),
    .calc_len(calc_len), .calc_ok(rx_ok),
    .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data), .pl_last(pl_last),
    .done(done), .done_len(done_len), .done_ok(done_ok)
  );

endmodule

// File: tb/eth_rx_fetch_bench.sv
module eth_rx_fetch_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] START_PTR = 16'h0120;

  logic clk, rst_n, start, cmd_valid, cmd_ready, rsp_valid;
  logic pl_valid, pl_ready, pl_last, done, done_ok;
  logic [15:0] max_len, done_len;
  logic [1:0]  cmd_kind;
  logic [7:0]  cmd_addr, cmd_wdata, rsp_data, pl_data;

  eth_rx_fetch #(.RX_START(START_PTR)) u_eth_rx_fetch (
    .clk(clk), .rst_n(rst_n), .start(start), .max_len(max_len),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data), .pl_last(pl_last),
    .done(done), .done_len(done_len), .done_ok(done_ok)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] bmem [0:2047];
  logic [1:0] log_k [0:255];
  logic [7:0] log_a [0:255];
  logic [7:0] log_d [0:255];
  logic [7:0] pl_got [0:255];
  logic       pl_lf  [0:255];
  int log_n, pl_n, done_cnt, pkt_count, proto_err, errors, checks;
  logic [15:0] rdp, cur_ptr;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_len_f(int bc, int ml, bit ok);
    int raw, cap;
    raw = (bc < 4) ? 0 : bc - 4;
    cap = (ml == 0) ? 0 : ml - 1;
    if (!ok) return 0;
    return (raw < cap) ? raw : cap;
  endfunction

  // access engine model
  initial begin
    logic [1:0] k;
    logic [7:0] a, d;
    cmd_ready = 1'b0; rsp_valid = 1'b0; rsp_data = '0; rdp = '0;
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (rst_n && cmd_valid && ($urandom_range(3) != 0)) begin
        cmd_ready = 1'b1;
        k = cmd_kind; a = cmd_addr; d = cmd_wdata;
        if (log_n < 256) begin log_k[log_n] = k; log_a[log_n] = a; log_d[log_n] = d; end
        log_n++;
        @(negedge clk);
        cmd_ready = 1'b0;
        if (cmd_valid) proto_err++;
        repeat ($urandom_range(2)) begin
          @(negedge clk);
          if (cmd_valid) proto_err++;
        end
        rsp_data = 8'h00;
        case (k)
          2'd0: rsp_data = (a == 8'h39) ? 8'(pkt_count) : 8'hEE;
          2'd1: begin
            if (a == 8'h00) rdp[7:0]  = d;
            if (a == 8'h01) rdp[15:8] = d;
          end
          2'd2: if (a == 8'h1E && d == 8'h40 && pkt_count > 0) pkt_count--;
          default: begin rsp_data = bmem[rdp[10:0]]; rdp = rdp + 16'd1; end
        endcase
        rsp_valid = 1'b1;
      end else begin
        cmd_ready = 1'b0;
      end
    end
  end

  // payload sink
  initial begin
    bit r;
    pl_ready = 1'b0;
    forever begin
      @(negedge clk);
      r = ($urandom_range(3) != 0);
      pl_ready = r;
      if (pl_valid && r) begin
        if (pl_n < 256) begin pl_got[pl_n] = pl_data; pl_lf[pl_n] = pl_last; end
        pl_n++;
      end
    end
  end

  initial begin
    done_cnt = 0;
    forever begin
      @(negedge clk);
      if (done) done_cnt++;
    end
  end

  task automatic chk_cmd(input int i, input int k, input int a, input int d,
                         input bit ad, input string tag);
    bit ok;
    ok = (int'(log_k[i]) == k) && (!ad || (int'(log_a[i]) == a && int'(log_d[i]) == d));
    chk(ok, tag, {log_k[i], log_a[i], log_d[i]}, {k[1:0], a[7:0], d[7:0]});
  endtask

  task automatic run_fetch(input int cnt, input int bc, input int ml,
                           input bit good, input bit restart);
    logic [15:0] nxt, st;
    int el, total, w, bad, base;
    bit got;
    nxt = (cur_ptr + 16'(bc + 8)) & 16'h07FE;
    st  = 16'($urandom_range(16'hFFFF));
    st[7] = good;
    bmem[11'(cur_ptr)]     = nxt[7:0];
    bmem[11'(cur_ptr + 1)] = nxt[15:8];
    bmem[11'(cur_ptr + 2)] = 8'(bc);
    bmem[11'(cur_ptr + 3)] = 8'(bc >> 8);
    bmem[11'(cur_ptr + 4)] = st[7:0];
    bmem[11'(cur_ptr + 5)] = st[15:8];
    for (int i = 0; i < bc; i++) bmem[11'(cur_ptr + 16'(6 + i))] = 8'($urandom_range(255));
    pkt_count = cnt; log_n = 0; pl_n = 0; done_cnt = 0;
    @(negedge clk); max_len = 16'(ml); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (restart) begin
      repeat (5) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    got = 0; w = 0;
    while (!got && w < 4000) begin
      @(negedge clk); w++;
      if (done) got = 1;
    end
    chk(got, "R10 done seen", got, 1);
    el = (cnt == 0) ? 0 : exp_len_f(bc, ml, good);
    chk(int'(done_len) == el, "R6 done_len", done_len, el);
    chk(done_ok == (cnt != 0 && good), "R7 done_ok", done_ok, (cnt != 0 && good));
    chk_cmd(0, 0, 8'h39, 0, 1, "R3 count read");
    total = (cnt == 0) ? 1 : 12 + el;
    if (cnt != 0) begin
      chk_cmd(1, 1, 8'h00, cur_ptr[7:0], 1, "R4 rdptr low");
      chk_cmd(2, 1, 8'h01, cur_ptr[15:8], 1, "R4 rdptr high");
      for (int i = 3; i < 9; i++) chk_cmd(i, 3, 0, 0, 0, "R5 header read");
      for (int i = 0; i < el; i++) chk_cmd(9 + i, 3, 0, 0, 0, "R8 payload read");
      base = 9 + el;
      chk_cmd(base,     1, 8'h0C, nxt[7:0],  1, "R9 free low");
      chk_cmd(base + 1, 1, 8'h0D, nxt[15:8], 1, "R9 free high");
      chk_cmd(base + 2, 2, 8'h1E, 8'h40,     1, "R9 decrement");
    end
    chk(pl_n == el, "R8 payload count", pl_n, el);
    bad = 0;
    for (int i = 0; i < el && i < 256; i++) begin
      if (pl_got[i] != bmem[11'(cur_ptr + 16'(6 + i))]) bad++;
      if (pl_lf[i] != (i == el - 1)) bad++;
    end
    chk(bad == 0, "R8 payload bytes and last", bad, 0);
    repeat (8) @(negedge clk);
    chk(log_n == total, "R11 command total", log_n, total);
    chk(done_cnt == 1, "R10 single done", done_cnt, 1);
    if (cnt != 0) cur_ptr = nxt;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R10 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    errors = 0; checks = 0; proto_err = 0; log_n = 0; pl_n = 0; pkt_count = 0;
    for (int i = 0; i < 2048; i++) bmem[i] = 8'h00;
    cur_ptr = START_PTR;
    rst_n = 1'b0; start = 1'b0; max_len = '0;
    repeat (3) @(negedge clk);
    chk(!cmd_valid && !pl_valid && !done, "R1 in reset", {cmd_valid, pl_valid, done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!cmd_valid && !pl_valid && !done, "R1 idle after reset", {cmd_valid, pl_valid, done}, 0);

    run_fetch(1, 20, 100, 1, 0);  // R4 first pointer from RX_START
    run_fetch(0, 10, 100, 1, 0);  // R3 no frame
    run_fetch(2, 30, 100, 0, 0);  // R7 bad status
    run_fetch(1, 2, 100, 1, 0);   // R6 count below CRC
    run_fetch(1, 4, 100, 1, 0);   // R8 good frame, zero length
    run_fetch(1, 12, 0, 1, 0);    // R6 limit zero
    run_fetch(1, 12, 1, 1, 0);    // R6 limit one
    run_fetch(1, 14, 11, 1, 0);   // R6 exactly at cap
    run_fetch(1, 15, 11, 1, 0);   // R6 over cap
    run_fetch(1, 5, 50, 1, 0);    // R8 single byte
    run_fetch(3, 25, 60, 1, 1);   // R11 start while busy
    for (int n = 0; n < 30; n++) begin
      run_fetch(($urandom_range(9) == 0) ? 0 : int'($urandom_range(3, 1)),
                int'($urandom_range(64)), int'($urandom_range(70)),
                ($urandom_range(3) != 0), ($urandom_range(4) == 0));
    end
    chk(proto_err == 0, "R2 single outstanding command", proto_err, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule